// File: doc/BRIEF.md
# Serial EEPROM SPI Slave

This block acts as the slave side of a four-wire serial link and behaves like a 512-byte electrically erasable memory. A host selects it by pulling the active-low select low and then clocks in an eight-bit command. Commands set or clear a write-permission flag, read or update a small status byte, and stream memory bytes in or out. The memory has nine address bits. The top address bit is carried in bit 3 of the command byte, and the next byte supplies the lower eight bits.

The serial pins are asynchronous to the block clock. They pass through a synchronizer, and the serial clock edges are found by oversampling, so the serial clock must run well below the system clock. A pause input can freeze a transfer part-way through a byte and later let it continue. An unknown command shuts the slave out until the next select. Memory writes are held in a page buffer and copied into the register-based array after the host deselects the device.

Top module: `eeprom_spi_slave`

## Requirements
- R1: After reset the output enable is low, the status byte reads 0x00 and every memory byte reads 0x00.
- R2: The first byte after select falls is the command, decoded with bits 7..4 zero as: 0x06 set write permission, 0x04 clear write permission, 0x05 status read, 0x01 status write, bits 2..0 = 011 memory read, bits 2..0 = 010 memory write. Any other byte is invalid.
- R3: Data moves most-significant bit first. SI is taken on the rising serial clock edge. SO changes only on the falling edge, and the first output bit appears on the falling edge that follows the last address or command bit.
- R4: Bit 3 of a memory read or write command is address bit 8, and the byte that follows is address bits 7..0, so the upper 256 bytes are reached when bit 3 is 1.
- R5: The write-permission flag is set by command 0x06 and cleared by reset, by command 0x04, and when select rises after a memory write or status write command.
- R6: The status byte is {0000, P1, P0, W, 0}. W (bit 1) is the write-permission flag and bit 0 always reads 0. The status read command returns this byte again and again while select stays low.
- R7: A status write stores data bits 3..2 into P1..P0 only when write permission is set. All other data bits are dropped.
- R8: A memory read returns the byte at the address and then each following byte, with the address wrapping from 0x1FF to 0x000.
- R9: Memory write data is buffered and written into the array after select rises, and only if write permission was set. Only complete bytes are written, at most PAGE_BYTES (16) of them, at addresses that rise and wrap like R8. Bytes beyond the page are dropped.
- R10: While select is high, SCK and SI have no effect and the output enable is low.
- R11: With select low, a low pause input seen while SCK is low freezes the transfer and drives the output enable low. SCK edges during the pause are ignored. Raising the pause input while SCK is low resumes the transfer exactly where it stopped.
- R12: After an invalid command, no later byte is acted on and the output enable stays low until the next falling edge of select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_ni | input | 1 | Active-low device select |
| sck_i | input | 1 | Serial clock from the host, idles low |
| si_i | input | 1 | Serial data into the slave |
| hold_ni | input | 1 | Active-low transfer pause |
| so_o | output | 1 | Serial data out of the slave |
| so_oe_o | output | 1 | Output enable for the serial data pad (low means high impedance) |

## Verification
The assertions assume that every serial pin holds steady for several system clocks around each SCK edge. They also assume that the pause input changes only while SCK is low and that select is not lowered again while a buffered write is still being copied into the array. The bench's host model meets these conditions by holding each SCK phase for eight system clocks. It moves SI and the pause input only in the low phase of SCK, and after each deselect it waits more than the longest copy time before the next select. Pulses on SCK during a pause are deliberate, because the pause rules must reject them.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  typedef enum logic [2:0] {
    CMD_SET_WE,
    CMD_CLR_WE,
    CMD_RD_STAT,
    CMD_WR_STAT,
    CMD_RD_MEM,
    CMD_WR_MEM,
    CMD_BAD
  } cmd_e;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_RD_DATA,
    PH_WR_DATA,
    PH_ST_OUT,
    PH_ST_IN,
    PH_SWALLOW,
    PH_LOCK
  } phase_e;

  // R2: command byte decode; bit 3 is don't-care for memory commands
  function automatic cmd_e decode_cmd(input logic [7:0] b);
    cmd_e c;
    c = CMD_BAD;
    if (b[7:4] == 4'h0) begin
      if (b[2:0] == 3'b011)      c = CMD_RD_MEM;
      else if (b[2:0] == 3'b010) c = CMD_WR_MEM;
      else if (b[3:0] == 4'h6)   c = CMD_SET_WE;
      else if (b[3:0] == 4'h4)   c = CMD_CLR_WE;
      else if (b[3:0] == 4'h5)   c = CMD_RD_STAT;
      else if (b[3:0] == 4'h1)   c = CMD_WR_STAT;
      else                       c = CMD_BAD;
    end
    return c;
  endfunction

endpackage

// File: rtl/esp_rst_sync.sv
module esp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/esp_pin_front.sv
// Synchronizes the serial pins, finds select/clock edges and tracks the pause state.
module esp_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic sel,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic held
);
  localparam int PINS = 4;
  localparam logic [PINS-1:0] PIN_IDLE = 4'b1001;  // cs high, sck low, si low, hold high

  logic [STAGES-1:0][PINS-1:0] sync_q;
  logic cs_s, sck_s, hold_s;
  logic sel_q, sck_q, held_q;
  logic sel_n, sck_n, held_n;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) sync_q[s] <= PIN_IDLE;
          else         sync_q[s] <= {cs_ni, sck_i, si_i, hold_ni};
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) sync_q[s] <= PIN_IDLE;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign cs_s   = sync_q[STAGES-1][3];
  assign sck_s  = sync_q[STAGES-1][2];
  assign si_s   = sync_q[STAGES-1][1];
  assign hold_s = sync_q[STAGES-1][0];

  always_comb begin
    sel_n = ~cs_s;
    sck_n = sck_s;
    // R11: the pause state may only change while the serial clock is low
    if (!sel_n)      held_n = 1'b0;
    else if (!sck_s) held_n = ~hold_s;
    else             held_n = held_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      sck_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      sel_q  <= sel_n;
      sck_q  <= sck_n;
      held_q <= held_n;
    end
  end

  assign sel      = sel_n;
  assign cs_fall  = sel_n & ~sel_q;
  assign cs_rise  = ~sel_n & sel_q;
  assign held     = held_q;
  assign sck_rise = sck_s & ~sck_q & sel_n & ~held_q;   // R10 R11
  assign sck_fall = ~sck_s & sck_q & sel_n & ~held_q;
endmodule

// File: rtl/esp_mem_array.sv
module esp_mem_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;   // R1
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/esp_engine.sv
// Command sequencer: shift registers, write-permission flag, status bits,
// page buffer and the copy of buffered bytes into the array.
module esp_engine
  import eeprom_spi_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              so,
  output logic              drive,
  output logic              we_latch,
  output logic              locked
);
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);

  phase_e            phase_q, phase_n;
  logic [2:0]        bit_q, bit_n;
  logic [6:0]        rx_q, rx_n;
  logic [7:0]        tx_q, tx_n;
  logic              so_q, so_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              rd_q, rd_n;
  logic              wr_q, wr_n;
  logic              mod_q, mod_n;
  logic              wel_q, wel_n;
  logic [1:0]        prot_q, prot_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              cp_act_q, cp_act_n;
  logic [CNT_W-1:0]  cp_idx_q, cp_idx_n;
  logic [CNT_W-1:0]  cp_len_q, cp_len_n;
  logic [ADDR_W-1:0] cp_base_q, cp_base_n;

  logic [7:0] pbuf [PAGE_BYTES];
  logic       buf_we;
  logic [7:0] byte_in;
  logic       byte_done;
  logic [7:0] status;
  cmd_e       cmd;

  assign byte_in   = {rx_q, si};
  assign byte_done = sck_rise && (bit_q == 3'd7) && (phase_q != PH_LOCK);
  assign status    = {4'b0000, prot_q, wel_q, 1'b0};   // R6
  assign cmd       = decode_cmd(byte_in);
  // R4: the address byte joins the high bit captured from the command
  assign mem_raddr = (phase_q == PH_ADDR) ? {addr_q[ADDR_W-1], byte_in} : addr_q;

  always_comb begin
    phase_n   = phase_q;
    bit_n     = bit_q;
    rx_n      = rx_q;
    tx_n      = tx_q;
    so_n      = so_q;
    addr_n    = addr_q;
    rd_n      = rd_q;
    wr_n      = wr_q;
    mod_n     = mod_q;
    wel_n     = wel_q;
    prot_n    = prot_q;
    base_n    = base_q;
    cnt_n     = cnt_q;
    cp_act_n  = cp_act_q;
    cp_idx_n  = cp_idx_q;
    cp_len_n  = cp_len_q;
    cp_base_n = cp_base_q;
    buf_we    = 1'b0;

    if (cp_act_q) begin
      cp_idx_n = cp_idx_q + CNT_W'(1);
      if (cp_idx_q == cp_len_q - CNT_W'(1)) cp_act_n = 1'b0;
    end

    if (cs_fall) begin
      phase_n = PH_CMD;          // R2, R12: fresh command after every select
      bit_n   = '0;
      rd_n    = 1'b0;
      wr_n    = 1'b0;
      mod_n   = 1'b0;
    end else if (cs_rise) begin
      phase_n = PH_IDLE;
      if (mod_q) wel_n = 1'b0;   // R5
      if (wr_q && wel_q && (cnt_q != '0)) begin   // R9
        cp_act_n  = 1'b1;
        cp_idx_n  = '0;
        cp_len_n  = cnt_q;
        cp_base_n = base_q;
      end
    end else begin
      if (sck_fall && drive) begin   // R3
        so_n = tx_q[7];
        tx_n = {tx_q[6:0], 1'b0};
      end
      if (sck_rise && (phase_q != PH_LOCK) && (phase_q != PH_IDLE)) begin
        rx_n  = {rx_q[5:0], si};
        bit_n = bit_q + 3'd1;
      end
      if (byte_done) begin
        unique case (phase_q)
          PH_CMD: begin
            unique case (cmd)
              CMD_SET_WE: begin wel_n = 1'b1; phase_n = PH_SWALLOW; end
              CMD_CLR_WE: begin wel_n = 1'b0; phase_n = PH_SWALLOW; end
              CMD_RD_STAT: begin tx_n = status; phase_n = PH_ST_OUT; end
              CMD_WR_STAT: begin mod_n = 1'b1; phase_n = PH_ST_IN; end
              CMD_RD_MEM: begin
                rd_n = 1'b1;
                addr_n[ADDR_W-1] = byte_in[3];
                phase_n = PH_ADDR;
              end
              CMD_WR_MEM: begin
                wr_n  = 1'b1;
                mod_n = 1'b1;
                addr_n[ADDR_W-1] = byte_in[3];
                phase_n = PH_ADDR;
              end
              default: phase_n = PH_LOCK;   // R12
            endcase
          end
          PH_ADDR: begin
            if (rd_q) begin
              tx_n    = mem_rdata;
              addr_n  = mem_raddr + ADDR_W'(1);
              phase_n = PH_RD_DATA;
            end else begin
              addr_n  = mem_raddr;
              base_n  = mem_raddr;
              cnt_n   = '0;
              phase_n = PH_WR_DATA;
            end
          end
          PH_RD_DATA: begin   // R8: wraps through the natural address width
            tx_n   = mem_rdata;
            addr_n = addr_q + ADDR_W'(1);
          end
          PH_ST_OUT: tx_n = status;
          PH_ST_IN: begin
            if (wel_q) prot_n = byte_in[3:2];   // R7
            phase_n = PH_SWALLOW;
          end
          PH_WR_DATA: begin
            if (cnt_q < PAGE_LIM) begin
              buf_we = 1'b1;
              cnt_n  = cnt_q + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      so_q      <= 1'b0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      wr_q      <= 1'b0;
      mod_q     <= 1'b0;
      wel_q     <= 1'b0;
      prot_q    <= '0;
      base_q    <= '0;
      cnt_q     <= '0;
      cp_act_q  <= 1'b0;
      cp_idx_q  <= '0;
      cp_len_q  <= '0;
      cp_base_q <= '0;
    end else begin
      phase_q   <= phase_n;
      bit_q     <= bit_n;
      rx_q      <= rx_n;
      tx_q      <= tx_n;
      so_q      <= so_n;
      addr_q    <= addr_n;
      rd_q      <= rd_n;
      wr_q      <= wr_n;
      mod_q     <= mod_n;
      wel_q     <= wel_n;
      prot_q    <= prot_n;
      base_q    <= base_n;
      cnt_q     <= cnt_n;
      cp_act_q  <= cp_act_n;
      cp_idx_q  <= cp_idx_n;
      cp_len_q  <= cp_len_n;
      cp_base_q <= cp_base_n;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[cnt_q[IDX_W-1:0]] <= byte_in;
  end

  assign mem_we    = cp_act_q;
  assign mem_waddr = cp_base_q + ADDR_W'(cp_idx_q);
  assign mem_wdata = pbuf[cp_idx_q[IDX_W-1:0]];
  assign so        = so_q;
  assign drive     = (phase_q == PH_RD_DATA) || (phase_q == PH_ST_OUT);
  assign we_latch  = wel_q;
  assign locked    = (phase_q == PH_LOCK);
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o
);
  localparam int DATA_W = 8;

  logic              rst_n_s;
  logic              sel, cs_fall, cs_rise, sck_rise, sck_fall, si_s, held;
  logic              drive, we_latch, locked, mem_we;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [DATA_W-1:0] mem_rdata, mem_wdata;

  esp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  esp_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_ni   (rst_n_s),
    .cs_ni    (cs_ni),
    .sck_i    (sck_i),
    .si_i     (si_i),
    .hold_ni  (hold_ni),
    .sel      (sel),
    .cs_fall  (cs_fall),
    .cs_rise  (cs_rise),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .si_s     (si_s),
    .held     (held)
  );

  esp_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_engine (
    .clk       (clk),
    .rst_ni    (rst_n_s),
    .cs_fall   (cs_fall),
    .cs_rise   (cs_rise),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .si        (si_s),
    .mem_rdata (mem_rdata),
    .mem_raddr (mem_raddr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .so        (so_o),
    .drive     (drive),
    .we_latch  (we_latch),
    .locked    (locked)
  );

  esp_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk    (clk),
    .rst_ni (rst_n_s),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .raddr  (mem_raddr),
    .rdata  (mem_rdata)
  );

  // R10 R11: pad released when deselected or paused
  assign so_oe_o = sel & ~held & drive;
endmodule

// File: rtl/eeprom_spi_sva.sv
module eeprom_spi_sva (
  input logic clk,
  input logic rst_ni,
  input logic sel,
  input logic held,
  input logic locked,
  input logic sck_rise,
  input logic sck_fall,
  input logic so,
  input logic so_oe,
  input logic mem_we,
  input logic we_latch
);
  AST_SO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_ni) !$stable(so) |-> $past(sck_fall)); // R3
  AST_WE_SET_BY_BYTE: assert property (@(posedge clk) disable iff (!rst_ni) $rose(we_latch) |-> $past(sck_rise)); // R5
  AST_COPY_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_ni) mem_we |-> !sel); // R9
  AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_ni) !sel |-> !so_oe); // R10
  AST_QUIET_PAUSED: assert property (@(posedge clk) disable iff (!rst_ni) held |-> !so_oe); // R11
  AST_QUIET_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni) locked && $past(locked) |-> !so_oe); // R12
endmodule

bind eeprom_spi_slave eeprom_spi_sva u_sva (
  .clk      (clk),
  .rst_ni   (rst_n_s),
  .sel      (sel),
  .held     (held),
  .locked   (locked),
  .sck_rise (sck_rise),
  .sck_fall (sck_fall),
  .so       (so_o),
  .so_oe    (so_oe_o),
  .mem_we   (mem_we),
  .we_latch (we_latch)
);

// File: tb/eeprom_spi_slave_test.sv
`timescale 1ns/1ps
module eeprom_spi_slave_test;
  localparam int H    = 8;
  localparam int PAGE = 16;

  logic clk = 1'b0;
  logic rst_ni, cs_n, sck, si, hold_n;
  wire  so, so_oe;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  bit quiet_req = 1'b0;
  int quiet_age = 0;

  logic [7:0] mem_m [0:511];
  bit         wel_m;
  logic [1:0] prot_m;
  logic [7:0] wbuf [0:31];

  always #4 clk = ~clk;

  eeprom_spi_slave uut (
    .clk(clk), .rst_ni(rst_ni), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat_m();
    return {4'b0000, prot_m, wel_m, 1'b0};
  endfunction

  // per-clock comparison against the model's quiet window (R10 R11 R12)
  always @(negedge clk) begin
    cyc++;
    if (quiet_req) quiet_age++;
    else           quiet_age = 0;
    if (quiet_age > 5) chk("R10/R11/R12 pad quiet", so_oe, 0);
    if (cyc > 150000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx, output bit oe_all);
    rx = '0;
    oe_all = 1'b1;
    for (int i = 7; i > 7 - nb; i--) begin
      si = tx[i];
      wait_clk(H);
      rx[i] = so;
      if (so_oe !== 1'b1) oe_all = 1'b0;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit oe);
    spi_bits(tx, 8, rx, oe);
  endtask

  task automatic sel_on();
    quiet_req = 1'b0;
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic sel_off();
    wait_clk(H);
    cs_n = 1'b1;
    quiet_req = 1'b1;
    wait_clk(4 * H);
  endtask

  task automatic do_cmd(input logic [7:0] op);
    logic [7:0] r; bit oe;
    sel_on(); xfer(op, r, oe); sel_off();
  endtask

  task automatic do_status(input string tag, input int reps);
    logic [7:0] r; bit oe;
    sel_on();
    xfer(8'h05, r, oe);
    for (int k = 0; k < reps; k++) begin
      xfer(8'h00, r, oe);
      chk(tag, r, stat_m());
      chk(tag, oe, 1);
    end
    sel_off();
  endtask

  task automatic do_wrstat(input logic [7:0] v);
    logic [7:0] r; bit oe;
    sel_on(); xfer(8'h01, r, oe); xfer(v, r, oe); sel_off();
    if (wel_m) prot_m = v[3:2];
    wel_m = 1'b0;
  endtask

  task automatic do_write(input logic [8:0] a, input int n, input int extra_bits);
    logic [7:0] r; bit oe;
    sel_on();
    xfer({4'b0000, a[8], 3'b010}, r, oe);
    xfer(a[7:0], r, oe);
    for (int k = 0; k < n; k++) xfer(wbuf[k], r, oe);
    if (extra_bits > 0) spi_bits(8'hA5, extra_bits, r, oe);
    sel_off();
    if (wel_m)
      for (int k = 0; k < n && k < PAGE; k++) mem_m[(a + k) % 512] = wbuf[k];
    wel_m = 1'b0;
  endtask

  task automatic do_read(input string tag, input logic [8:0] a, input int n);
    logic [7:0] r; bit oe;
    sel_on();
    xfer({4'b0000, a[8], 3'b011}, r, oe);
    xfer(a[7:0], r, oe);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r, oe);
      chk(tag, r, mem_m[(a + k) % 512]);
      chk(tag, oe, 1);
    end
    sel_off();
  endtask

  // R11: second data byte paused after three bits, with ignored SCK pulses
  task automatic do_read_paused(input logic [8:0] a);
    logic [7:0] r; bit oe;
    sel_on();
    xfer({4'b0000, a[8], 3'b011}, r, oe);
    xfer(a[7:0], r, oe);
    xfer(8'h00, r, oe);
    chk("R11 byte before pause", r, mem_m[a]);
    r = '0;
    for (int i = 7; i >= 0; i--) begin
      if (i == 4) begin
        hold_n = 1'b0;
        quiet_req = 1'b1;
        wait_clk(3 * H);
        chk("R11 pad off while paused", so_oe, 0);
        for (int p = 0; p < 3; p++) begin
          sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
        end
        quiet_req = 1'b0;
        hold_n = 1'b1;
        wait_clk(H);
      end
      si = 1'b0;
      wait_clk(H);
      r[i] = so;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
    chk("R11 byte across pause", r, mem_m[(a + 1) % 512]);
    xfer(8'h00, r, oe);
    chk("R11 byte after pause", r, mem_m[(a + 2) % 512]);
    sel_off();
  endtask

  initial begin
    logic [7:0] r; bit oe;
    for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
    wel_m = 1'b0; prot_m = 2'b00;
    cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    rst_ni = 1'b0;
    wait_clk(10);
    rst_ni = 1'b1;
    wait_clk(10);

    chk("R1 pad off after reset", so_oe, 0);
    do_status("R1 status after reset", 1);
    do_read("R1 array cleared", 9'h000, 1);
    do_read("R1 array cleared top", 9'h1FF, 1);

    // R9: write without permission is dropped
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(9'h020, 2, 0);
    do_read("R9 write without permission", 9'h020, 2);

    // R5 R6: permission visible in bit 1, status repeats
    do_cmd(8'h06); wel_m = 1'b1;
    do_status("R5/R6 status repeats with W set", 2);

    // R2 R3 R8: basic write then read back, asymmetric bit patterns
    wbuf[0] = 8'h80; wbuf[1] = 8'h01; wbuf[2] = 8'hC3;
    do_write(9'h010, 3, 0);
    do_status("R5 W cleared after write", 1);
    do_read("R3/R8 read back", 9'h010, 3);

    // R4: upper half through command bit 3
    do_cmd(8'h06); wel_m = 1'b1;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(9'h1F0, 4, 0);
    do_read("R4 upper half", 9'h1F0, 4);
    do_read("R4 lower alias untouched", 9'h0F0, 1);

    // R8 R9: wrap across the top of the array
    do_cmd(8'h06); wel_m = 1'b1;
    wbuf[0] = 8'h5E; wbuf[1] = 8'h6F; wbuf[2] = 8'h70;
    do_write(9'h1FE, 3, 0);
    do_read("R8 read wraps", 9'h1FE, 4);

    // R5: clear command
    do_cmd(8'h06); wel_m = 1'b1;
    do_cmd(8'h04); wel_m = 1'b0;
    do_status("R5 clear command", 1);

    // R7: status write gated, only bits 3..2 stored
    do_wrstat(8'h0C);
    do_status("R7 status write without W", 1);
    do_cmd(8'h06); wel_m = 1'b1;
    do_wrstat(8'hFF);
    do_status("R7/R6 protection bits stored", 1);
    do_cmd(8'h06); wel_m = 1'b1;
    do_wrstat(8'h00);
    do_status("R7 protection bits cleared", 1);

    // R9: trailing partial byte dropped
    do_cmd(8'h06); wel_m = 1'b1;
    wbuf[0] = 8'h5A;
    do_write(9'h040, 1, 4);
    do_read("R9 partial byte dropped", 9'h040, 2);

    // R9: page limit
    do_cmd(8'h06); wel_m = 1'b1;
    for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h30 + k);
    do_write(9'h080, 18, 0);
    do_read("R9 page limit", 9'h080, 18);

    // R11
    do_read_paused(9'h07F);

    // R12: invalid command locks out a following set-permission and status read
    sel_on();
    xfer(8'hFF, r, oe);
    quiet_req = 1'b1;
    xfer(8'h06, r, oe);
    xfer(8'h05, r, oe);
    xfer(8'h00, r, oe);
    chk("R12 pad stays off after invalid command", oe, 0);
    sel_off();
    do_status("R12 nothing acted on", 1);

    // R10: bits clocked while deselected are ignored
    quiet_req = 1'b1;
    spi_bits(8'h06, 8, r, oe);
    chk("R10 pad off while deselected", oe, 0);
    wait_clk(2 * H);
    do_status("R10 deselected bits ignored", 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule